// File: doc/BRIEF.md
# Pipelined Constant-Time Carry-Less Multiplier

This block multiplies two 64-bit polynomials over GF(2) and returns their full 128-bit carry-less product. Each operation presents two 128-bit source words and an 8-bit select byte. The select byte picks the lower or upper 64-bit half of each source, and those two halves are multiplied. Partial products are combined by XOR only, so no carry ever moves between bit positions.

The unit is fully pipelined. It can take a new operation on every clock, and each result appears exactly seven cycles after its operation was accepted. This timing holds whatever the operand values or the select byte are, which makes the block suitable for cryptographic code that must not leak data through its timing. A 6-bit tag travels with each operation and is returned with the result, so the caller can match results to requests. There is no stall input: every accepted operation completes on schedule.

Top module: `clmul_pipe`

## Requirements
- R1: When `res_valid` is high, `res_prod` equals the carry-less product of the two selected 64-bit halves. Bit i of the product is the XOR over all j of `a[j] & b[i-j]`.
- R2: Select bit 0 picks the half of source A: 0 uses bits 63:0 and 1 uses bits 127:64.
- R3: Select bit 4 picks the half of source B in the same way. Select bits 7:5 and 3:1 have no effect on the result.
- R4: `res_valid` is high exactly 7 clock edges after the edge that accepted `op_valid`, whatever the operand and select values are.
- R5: `res_tag` carries the tag that was given with the matching operation.
- R6: A synchronous active-high `rst` drops every operation in flight. `res_valid` stays low until 7 edges after the next accepted operation.
- R7: Bit 127 of `res_prod` is 0 whenever `res_valid` is high.
- R8: Operations may be issued on consecutive cycles, with or without gaps. Results come back one per cycle in issue order.
- R9: If either selected half is zero, the product is zero. If one selected half equals 1, the product is the other selected half zero-extended to 128 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| op_valid | input | 1 | Accept an operation this cycle |
| op_tag | input | 6 | Tag returned with the result |
| op_a | input | 128 | Source A |
| op_b | input | 128 | Source B |
| op_sel | input | 8 | Half select: bit 0 for A, bit 4 for B |
| res_valid | output | 1 | Result valid |
| res_tag | output | 6 | Tag of the result |
| res_prod | output | 128 | Carry-less product |

## Verification
The bound checker keeps its own history of accepted operations. On every cycle it checks four things: that each result appears exactly seven edges after its request (R4), that the tag matches (R5), that a reset clears the output valid (R6), and that bit 127 is clear. It also checks that an operation whose selected half is zero yields a zero product (R9). The value of non-trivial products, the effect of each select bit, the insensitivity to the unused select bits, and in-order delivery under back-to-back traffic with gaps can only be shown by the bench's directed scenarios. Those scenarios compare every cycle against an independent reference model.

// File: rtl/clmul_pipe.sv
module clmul_pipe #(
  parameter int W      = 64,
  parameter int TAGW   = 6,
  parameter int STAGES = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [TAGW-1:0]   op_tag,
  input  logic [2*W-1:0]    op_a,
  input  logic [2*W-1:0]    op_b,
  input  logic [7:0]        op_sel,
  output logic              res_valid,
  output logic [TAGW-1:0]   res_tag,
  output logic [2*W-1:0]    res_prod
);

  localparam int NACC  = STAGES - 1;
  localparam int CHUNK = (W + NACC - 1) / NACC;

  function automatic logic [2*W-1:0] chunk_xor(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input int base);
    logic [2*W-1:0] r;
    r = '0;
    for (int k = 0; k < CHUNK; k++)
      if (base + k < W)
        if (b[base + k]) r = r ^ ({{W{1'b0}}, a} << (base + k));
    return r;
  endfunction

  logic [STAGES-1:0] vld_q;
  logic [TAGW-1:0]   tag_q [STAGES];
  logic [W-1:0]      a_q   [NACC];
  logic [W-1:0]      b_q   [NACC];
  logic [2*W-1:0]    acc_q [1:STAGES-1];

  wire unused_sel = ^{op_sel[7:5], op_sel[3:1]};

  always_ff @(posedge clk)
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[STAGES-2:0], op_valid};

  always_ff @(posedge clk) begin
    tag_q[0] <= op_tag;
    a_q[0]   <= op_sel[0] ? op_a[2*W-1:W] : op_a[W-1:0];
    b_q[0]   <= op_sel[4] ? op_b[2*W-1:W] : op_b[W-1:0];
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    logic [2*W-1:0] prev;
    if (s == 1) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = acc_q[s-1];
    end

    always_ff @(posedge clk) begin
      tag_q[s] <= tag_q[s-1];
      acc_q[s] <= prev ^ chunk_xor(a_q[s-1], b_q[s-1], (s-1) * CHUNK);
    end

    if (s < NACC) begin : g_pass
      always_ff @(posedge clk) begin
        a_q[s] <= a_q[s-1];
        b_q[s] <= b_q[s-1];
      end
    end
  end

  assign res_valid = vld_q[STAGES-1];
  assign res_tag   = tag_q[STAGES-1];
  assign res_prod  = acc_q[STAGES-1];

endmodule

// File: rtl/clmul_pipe_chk.sv
module clmul_pipe_chk #(
  parameter int W      = 64,
  parameter int TAGW   = 6,
  parameter int STAGES = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [TAGW-1:0] op_tag,
  input logic [2*W-1:0]  op_a,
  input logic [2*W-1:0]  op_b,
  input logic [7:0]      op_sel,
  input logic            res_valid,
  input logic [TAGW-1:0] res_tag,
  input logic [2*W-1:0]  res_prod
);

  logic [STAGES-1:0] vh;
  logic [STAGES-1:0] zh;
  logic [TAGW-1:0]   th [STAGES];

  wire unused_sel_chk = ^{op_sel[7:5], op_sel[3:1]};
  wire [W-1:0] ha = op_sel[0] ? op_a[2*W-1:W] : op_a[W-1:0];
  wire [W-1:0] hb = op_sel[4] ? op_b[2*W-1:W] : op_b[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      vh <= '0;
      zh <= '0;
    end else begin
      vh <= {vh[STAGES-2:0], op_valid};
      zh <= {zh[STAGES-2:0], (ha == '0) || (hb == '0)};
    end
    th[0] <= op_tag;
    for (int i = 1; i < STAGES; i++) th[i] <= th[i-1];
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_valid == vh[STAGES-1]);                                   // R4
  AST_TAG_RETURN: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_tag == th[STAGES-1]);                       // R5
  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !res_valid);                                          // R6
  AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !res_prod[2*W-1]);                              // R7
  AST_ZERO_ANNIHILATES: assert property (@(posedge clk) disable iff (rst)
    (res_valid && zh[STAGES-1]) |-> res_prod == '0);              // R9

endmodule

bind clmul_pipe clmul_pipe_chk #(.W(W), .TAGW(TAGW), .STAGES(STAGES)) u_chk (.*);

// File: tb/clmul_pipe_test.sv
module clmul_pipe_test;
  localparam int LAT = 7;
  localparam int MAXN = 64;

  logic         clk = 0;
  logic         rst = 1;
  logic         op_valid = 0;
  logic [5:0]   op_tag = 0;
  logic [127:0] op_a = 0, op_b = 0;
  logic [7:0]   op_sel = 0;
  logic         res_valid;
  logic [5:0]   res_tag;
  logic [127:0] res_prod;

  int total = 0, bad = 0;

  logic         q_v   [MAXN];
  logic [5:0]   q_tag [MAXN];
  logic [127:0] q_a   [MAXN];
  logic [127:0] q_b   [MAXN];
  logic [7:0]   q_sel [MAXN];

  clmul_pipe uut (.*);

  always #5 clk = ~clk;

  function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 64; i++) if (b[i]) r ^= {64'b0, a} << i;
    return r;
  endfunction

  function automatic logic [127:0] expect_of(input int i);
    logic [63:0] ha, hb;
    ha = q_sel[i][0] ? q_a[i][127:64] : q_a[i][63:0];
    hb = q_sel[i][4] ? q_b[i][127:64] : q_b[i][63:0];
    return ref_mul(ha, hb);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_queue(input int n, input string req);
    for (int c = 0; c < n + LAT + 2; c++) begin
      @(negedge clk);
      if (c >= LAT && c - LAT < n && q_v[c-LAT]) begin
        chk(res_valid === 1'b1, {req, " R4 valid"}, {127'b0, res_valid}, 128'd1);
        chk(res_tag === q_tag[c-LAT], {req, " R5 tag"}, {122'b0, res_tag}, {122'b0, q_tag[c-LAT]});
        chk(res_prod === expect_of(c-LAT), {req, " R1 product"}, res_prod, expect_of(c-LAT));
      end else begin
        chk(res_valid === 1'b0, {req, " R4 idle"}, {127'b0, res_valid}, 128'd0);
      end
      if (c < n) begin
        op_valid = q_v[c]; op_tag = q_tag[c]; op_a = q_a[c]; op_b = q_b[c]; op_sel = q_sel[c];
      end else begin
        op_valid = 0; op_a = {4{$urandom}}; op_b = {4{$urandom}};
      end
    end
  endtask

  task automatic put(input int i, input logic v, input logic [127:0] a, input logic [127:0] b, input logic [7:0] s);
    q_v[i] = v; q_tag[i] = 6'(i + 17); q_a[i] = a; q_b[i] = b; q_sel[i] = s;
  endtask

  task automatic t_reset;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(res_valid === 1'b0, "R6 reset state", {127'b0, res_valid}, 128'd0);
    end
  endtask

  task automatic t_basic;
    put(0, 1, 128'h3, 128'h3, 8'h00);
    put(1, 1, 128'h7, 128'h5, 8'h00);
    put(2, 1, 128'h8000_0000_0000_0001, 128'h8000_0000_0000_0001, 8'h00);
    put(3, 1, 128'h1234_5678_9abc_def0, 128'h0fed_cba9_8765_4321, 8'h00);
    run_queue(4, "R1 basic");
    chk(ref_mul(64'h3, 64'h3) === 128'h5, "R1 model 3x3", ref_mul(64'h3, 64'h3), 128'h5);
  endtask

  task automatic t_halves;
    logic [127:0] a = {64'hdead_beef_0bad_f00d, 64'h0000_0000_0000_0003};
    logic [127:0] b = {64'h0000_0000_0000_0005, 64'hcafe_babe_1357_9bdf};
    put(0, 1, a, b, 8'h00);
    put(1, 1, a, b, 8'h01);
    put(2, 1, a, b, 8'h10);
    put(3, 1, a, b, 8'h11);
    put(4, 1, a, b, 8'hEE);
    put(5, 1, a, b, 8'hFF);
    put(6, 1, a, b, 8'hE1);
    run_queue(7, "R2 R3 halves");
  endtask

  task automatic t_zero_one;
    logic [63:0] x = 64'hf0e1_d2c3_b4a5_9687;
    put(0, 1, {x, 64'h0}, {64'h1, x}, 8'h00);
    put(1, 1, {x, 64'h0}, {64'h1, x}, 8'h11);
    put(2, 1, {64'h1, x}, {64'h0, x}, 8'h01);
    put(3, 1, {64'h0, x}, 128'h0, 8'h10);
    run_queue(4, "R9 zero one");
  endtask

  task automatic t_top_bit;
    put(0, 1, {128{1'b1}}, {128{1'b1}}, 8'h11);
    put(1, 1, {64'h0, 64'h8000_0000_0000_0000}, {64'h0, 64'h8000_0000_0000_0000}, 8'h00);
    run_queue(2, "R7 top bit");
    chk(ref_mul('1, '1) == {2'b01, {63{2'b01}}}, "R7 model", ref_mul('1, '1), {2'b01, {63{2'b01}}});
  endtask

  task automatic t_stream;
    for (int i = 0; i < 40; i++)
      put(i, (i % 7) != 3, {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom}, 8'($urandom));
    run_queue(40, "R8 stream");
  endtask

  task automatic t_reset_flight;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      op_valid = 1; op_tag = 6'(c); op_a = 128'h5; op_b = 128'h9; op_sel = 0;
    end
    @(negedge clk); op_valid = 0; rst = 1;
    @(negedge clk); rst = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk(res_valid === 1'b0, "R6 flush", {127'b0, res_valid}, 128'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 0;
    t_basic;
    t_halves;
    t_zero_one;
    t_top_bit;
    t_stream;
    t_reset_flight;
    t_basic;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule